// File: doc/BRIEF.md
# Serial Interrupt Frame Encoder

This block lets a peripheral report twenty interrupt levels to a host over one shared serial wire. The wire is open-drain style: a pull-up holds it high, and any agent may drive it for a clock. The host owns each frame. It pulls the wire low to open a frame, walks through a fixed sequence of three-clock slots, and pulls the wire low again to close the frame. In each slot the block drives a low if that slot's interrupt is asserted. It then drives one clock of high to restore the wire, and then lets go. All timing is counted on the PCI clock, and the wire is sampled on its rising edge.

The twenty slots are sixteen ISA-style request lines followed by the four PCI interrupt lines. A system management request can share the IRQ2 slot when a mapping input allows it. The block contains a small state machine with these states:

- ST_IDLE: waiting for the wire to go low.
- ST_START: counting the low clocks of the host's opening pulse.
- ST_SAMPLE, ST_RECOVER, ST_TURN: the three phases of each slot.
- ST_STOP_WAIT and ST_STOP_LOW: sitting out the host's closing pulse.

The transitions are:

- IDLE to START when a low is seen.
- START to SAMPLE when the wire returns high after an accepted pulse length.
- START to IDLE when the wire returns high after a rejected pulse length.
- SAMPLE to RECOVER to TURN inside a slot.
- TURN to SAMPLE for the next slot.
- TURN to STOP_WAIT after the last slot.
- STOP_WAIT to STOP_LOW on a low.
- STOP_LOW to IDLE on a high.

Top module: `sirq_frame_enc`

## Requirements
- R1: While reset is asserted, and after it until a valid opening pulse has been seen, `sio_oe` stays 0.
- R2: An opening pulse is accepted when `sio_in` is sampled low on 4 to 8 consecutive rising edges and then sampled high. Call that high edge E. The sample phase of slot 0 is presented in the clock period that follows E.
- R3: An opening pulse of fewer than 4 or more than 8 low samples is rejected. No slot is driven afterwards, and the block waits for the next low.
- R4: Each slot lasts three clocks. For an asserted slot, the block drives low (`sio_oe`=1, `sio_drv`=0) in the sample phase, drives high (`sio_oe`=1, `sio_drv`=1) in the recovery phase, and releases the wire (`sio_oe`=0) in the turnaround phase.
- R5: For an unasserted slot, `sio_oe` is 0 in all three phases.
- R6: Slots follow this order. Slot k for k=0..15 is `isa_req[k]`. Slot 16+j for j=0..3 is `pci_req[j]`, where bit 0 is INTA and bit 3 is INTD. The sample phase of slot k falls in the period after edge E+3k.
- R7: Slot 2 is asserted when `isa_req[2]` is 1, or when both `smi_req` and `smi_on_irq2` are 1. When `smi_on_irq2` is 0, `smi_req` has no effect.
- R8: After the last slot's turnaround, the block does not drive while it waits for the closing low pulse. Once the wire is sampled high again it returns to waiting for an opening pulse. The closing pulse itself, even one 4 to 8 clocks long, never opens a frame.
- R9: The request is taken live in the sample phase. The recovery phase drives high only if the sample phase just before it drove low, even if the request changed in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sio_in | input | 1 | Sampled level of the shared serial wire |
| isa_req | input | 16 | ISA-style interrupt requests, active high |
| pci_req | input | 4 | PCI interrupt requests INTA..INTD, active high |
| smi_req | input | 1 | System management interrupt request, active high |
| smi_on_irq2 | input | 1 | Maps the SMI request onto the IRQ2 slot when 1 |
| sio_oe | output | 1 | Drive enable for the serial wire |
| sio_drv | output | 1 | Value driven when `sio_oe` is 1 |

## Verification
The hardest case to reach is a request that changes between a slot's sample phase and its recovery phase, since R9 only shows up when an input moves inside a single three-clock slot. The random frames therefore draw new request vectors on every clock during the slot walk. The bench's expected output keeps the sample decision of the previous cycle. Directed frames cover the boundary pulse lengths of 3, 4, 8 and 9 clocks, the SMI mapping in both settings, and a closing pulse long enough to look like an opening one.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SAMPLE,
        ST_RECOVER,
        ST_TURN,
        ST_STOP_WAIT,
        ST_STOP_LOW
    } sirq_state_e;

endpackage

// File: rtl/sirq_low_timer.sv
// Counts consecutive low samples of the serial wire; clears on a high sample.
module sirq_low_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic [CNT_W-1:0] low_cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (line_in) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_TOP) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sirq_slot_map.sv
// Flattens the request inputs into slot order, merging SMI into its slot.
module sirq_slot_map #(
    parameter int NUM_ISA  = 16,
    parameter int NUM_PCI  = 4,
    parameter int SMI_SLOT = 2,
    localparam int NUM_SLOTS = NUM_ISA + NUM_PCI
) (
    input  logic [NUM_ISA-1:0]   isa_req,
    input  logic [NUM_PCI-1:0]   pci_req,
    input  logic                 smi_req,
    input  logic                 smi_on_slot,
    output logic [NUM_SLOTS-1:0] slot_vec
);
    for (genvar g = 0; g < NUM_ISA; g++) begin : g_isa
        if (g == SMI_SLOT) begin : g_merge
            assign slot_vec[g] = isa_req[g] | (smi_req & smi_on_slot);
        end else begin : g_plain
            assign slot_vec[g] = isa_req[g];
        end
    end

    for (genvar p = 0; p < NUM_PCI; p++) begin : g_pci
        assign slot_vec[NUM_ISA+p] = pci_req[p];
    end
endmodule

// File: rtl/sirq_frame_fsm.sv
// Frame sequencer: start detection, slot walk, stop wait.
module sirq_frame_fsm
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS = 20,
    parameter int START_MIN = 4,
    parameter int START_MAX = 8,
    parameter int CNT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    input  logic [CNT_W-1:0]     low_cnt,
    input  logic [NUM_SLOTS-1:0] slot_vec,
    output logic                 line_oe,
    output logic                 line_drv
);
    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);
    localparam logic [CNT_W-1:0] LEN_MIN  = CNT_W'(START_MIN);
    localparam logic [CNT_W-1:0] LEN_MAX  = CNT_W'(START_MAX);

    sirq_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             drove_q;
    logic             cur_req;
    logic             len_ok;

    assign cur_req = slot_vec[idx_q];
    assign len_ok  = (low_cnt >= LEN_MIN) && (low_cnt <= LEN_MAX);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (!line_in) state_d = ST_START;
            ST_START:     if (line_in)  state_d = len_ok ? ST_SAMPLE : ST_IDLE;
            ST_SAMPLE:    state_d = ST_RECOVER;
            ST_RECOVER:   state_d = ST_TURN;
            ST_TURN:      state_d = (idx_q == LAST_IDX) ? ST_STOP_WAIT : ST_SAMPLE;
            ST_STOP_WAIT: if (!line_in) state_d = ST_STOP_LOW;
            ST_STOP_LOW:  if (line_in)  state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register with slot index and sample memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            drove_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_START) begin
                idx_q <= '0;
            end else if (state_q == ST_TURN && idx_q != LAST_IDX) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_SAMPLE) begin
                drove_q <= cur_req;
            end
        end
    end

    // Output decode
    always_comb begin
        line_oe  = 1'b0;
        line_drv = 1'b1;
        unique case (state_q)
            ST_SAMPLE: begin
                line_oe  = cur_req;
                line_drv = 1'b0;
            end
            ST_RECOVER: begin
                line_oe  = drove_q;
                line_drv = 1'b1;
            end
            default: begin
                line_oe  = 1'b0;
                line_drv = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sirq_frame_enc.sv
module sirq_frame_enc #(
    parameter int NUM_ISA   = 16,
    parameter int NUM_PCI   = 4,
    parameter int SMI_SLOT  = 2,
    parameter int START_MIN = 4,
    parameter int START_MAX = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sio_in,
    input  logic [NUM_ISA-1:0] isa_req,
    input  logic [NUM_PCI-1:0] pci_req,
    input  logic               smi_req,
    input  logic               smi_on_irq2,
    output logic               sio_oe,
    output logic               sio_drv
);
    localparam int NUM_SLOTS = NUM_ISA + NUM_PCI;
    localparam int CNT_W     = $clog2(START_MAX + 2);

    logic [CNT_W-1:0]     low_cnt;
    logic [NUM_SLOTS-1:0] slot_vec;

    sirq_low_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (sio_in),
        .low_cnt (low_cnt)
    );

    sirq_slot_map #(
        .NUM_ISA  (NUM_ISA),
        .NUM_PCI  (NUM_PCI),
        .SMI_SLOT (SMI_SLOT)
    ) u_map (
        .isa_req     (isa_req),
        .pci_req     (pci_req),
        .smi_req     (smi_req),
        .smi_on_slot (smi_on_irq2),
        .slot_vec    (slot_vec)
    );

    sirq_frame_fsm #(
        .NUM_SLOTS (NUM_SLOTS),
        .START_MIN (START_MIN),
        .START_MAX (START_MAX),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (sio_in),
        .low_cnt  (low_cnt),
        .slot_vec (slot_vec),
        .line_oe  (sio_oe),
        .line_drv (sio_drv)
    );
endmodule

// File: rtl/sirq_frame_chk.sv
module sirq_frame_chk (
    input logic clk,
    input logic rst_n,
    input logic sio_oe,
    input logic sio_drv
);
    // R1: never drive while held in reset
    a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> !sio_oe);

    // R4: a driven low is followed by a driven high
    a_r4_recover_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe && !sio_drv) |=> (sio_oe && sio_drv));

    // R4: a driven high is followed by release
    a_r4_turn_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe && sio_drv) |=> !sio_oe);

    // R9: a driven high only follows a driven low
    a_r9_high_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe && sio_drv) |-> $past(sio_oe && !sio_drv));

    // R4: the drive value is never unknown while enabled
    a_r4_drive_known: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe |-> !$isunknown(sio_drv));
endmodule

bind sirq_frame_enc sirq_frame_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sio_oe  (sio_oe),
    .sio_drv (sio_drv)
);

// File: tb/sim_sirq_frame_enc.sv
`timescale 1ns/1ps
module sim_sirq_frame_enc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_low = 1'b0;
    logic [15:0] isa_req = '0;
    logic [3:0]  pci_req = '0;
    logic        smi_req = 1'b0;
    logic        smi_on_irq2 = 1'b0;
    logic        sio_oe, sio_drv, sio_in;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    // Wire with pull-up: host low wins, else device drive, else high
    assign sio_in = host_low ? 1'b0 : (sio_oe ? sio_drv : 1'b1);

    sirq_frame_enc u0 (
        .clk(clk), .rst_n(rst_n), .sio_in(sio_in),
        .isa_req(isa_req), .pci_req(pci_req),
        .smi_req(smi_req), .smi_on_irq2(smi_on_irq2),
        .sio_oe(sio_oe), .sio_drv(sio_drv)
    );

    function automatic bit slot_bit(int k, logic [15:0] isa, logic [3:0] pci,
                                    logic smi, logic map);
        if (k < 16) return isa[k] | ((k == 2) & smi & map);
        return pci[k-16];
    endfunction

    task automatic check(bit ok, string req, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got oe/drv=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_quiet(string req);
        check(sio_oe == 1'b0, req, {sio_oe, sio_drv}, 2'b0x);
    endtask

    // One host frame: opening pulse of len clocks, slot walk, closing pulse
    task automatic run_frame(int len, int stop_len, bit mid);
        bit valid = (len >= 4) && (len <= 8);
        bit drove = 1'b0;
        @(negedge clk);
        host_low = 1'b1;
        repeat (len) begin
            @(negedge clk);
            check_quiet("R2");
        end
        host_low = 1'b0;
        if (!valid) begin
            isa_req = '1; pci_req = '1;
            repeat (64) begin
                @(negedge clk);
                check_quiet("R3");
            end
            return;
        end
        // R6: slot k sample is the period after edge E+3k
        for (int k = 0; k < 20; k++) begin
            for (int ph = 0; ph < 3; ph++) begin
                @(negedge clk);
                if (mid) begin
                    isa_req = 16'($urandom); pci_req = 4'($urandom);
                    smi_req = 1'($urandom); smi_on_irq2 = 1'($urandom);
                end
                #1;
                if (ph == 0) begin
                    bit e = slot_bit(k, isa_req, pci_req, smi_req, smi_on_irq2);
                    string tg = (k == 2 && smi_req) ? "R7" : (e ? "R4" : "R5");
                    check((sio_oe == e) && (!e || sio_drv == 1'b0),
                          $sformatf("%s R6 slot %0d sample", tg, k),
                          {sio_oe, sio_drv}, {e, 1'b0});
                    drove = e;
                end else if (ph == 1) begin
                    check((sio_oe == drove) && (!drove || sio_drv == 1'b1),
                          $sformatf("R9 slot %0d recovery", k),
                          {sio_oe, sio_drv}, {drove, 1'b1});
                end else begin
                    check(sio_oe == 1'b0, $sformatf("R4 slot %0d turnaround", k),
                          {sio_oe, sio_drv}, 2'b0x);
                end
            end
        end
        isa_req = '1; pci_req = '1;
        repeat (3) begin
            @(negedge clk);
            check_quiet("R8 before stop");
        end
        host_low = 1'b1;
        repeat (stop_len) begin
            @(negedge clk);
            check_quiet("R8 stop");
        end
        host_low = 1'b0;
        repeat ((stop_len > 3) ? 64 : 4) begin
            @(negedge clk);
            check_quiet("R8 after stop");
        end
    endtask

    initial begin
        void'($urandom(32'h51a7));
        isa_req = '1; pci_req = '1;
        repeat (3) begin
            @(negedge clk);
            check_quiet("R1 in reset");
        end
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check_quiet("R1 after reset");
        end
        // R2 boundary lengths, R6 ordering with sparse patterns
        isa_req = 16'h8005; pci_req = 4'b1010;
        run_frame(4, 2, 1'b0);
        isa_req = '1; pci_req = '1;
        run_frame(8, 3, 1'b0);
        // R3 rejected lengths
        run_frame(3, 2, 1'b0);
        run_frame(9, 2, 1'b0);
        // R7 SMI mapped and unmapped
        isa_req = '0; pci_req = '0; smi_req = 1'b1; smi_on_irq2 = 1'b1;
        run_frame(5, 2, 1'b0);
        isa_req = '0; pci_req = '0; smi_req = 1'b1; smi_on_irq2 = 1'b0;
        run_frame(6, 3, 1'b0);
        // R8 long closing pulse does not open a frame
        isa_req = 16'h0f0f; pci_req = 4'b0101; smi_req = 1'b0;
        run_frame(7, 6, 1'b0);
        isa_req = 16'h1234; pci_req = 4'b0001;
        run_frame(4, 2, 1'b0);
        // Random frames with requests moving every clock (R9)
        for (int i = 0; i < 20; i++) begin
            run_frame(4 + int'($urandom_range(4)), 2 + int'($urandom_range(1)), 1'b1);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule